// File: doc/BRIEF.md
# Four-Channel Shared-Timebase PWM Generator

The block generates up to four pulse-width-modulated outputs from one shared timebase. A prescaler divides the input clock, and an up-counter counts the divided ticks from zero to a programmable limit and then wraps. Every channel compares this common count against its own threshold to form a reference level. The reference then drives a main output and, when the build enables it, a complementary output. Each output can be enabled and inverted on its own. A single master gate can silence all outputs at once.

Software controls the block through a flat register port with a word address, write data, a write strobe and combinational read data. The prescaler value is always double-buffered. The period limit and the compare thresholds are double-buffered when their preload bits are set. A buffered value moves into the active copy on an update event. An update event is either a counter wrap or a software request, and a software request also restarts the counter and the prescaler from zero. Channels share one period, so only the duty cycle can differ between channels.

Top module: `pwm_tmr_core`

## Requirements
- R1: The counter advances once every (divider value + 1) clocks while running, so one period lasts (limit + 1) × (divider + 1) clocks.
- R2: With polarity 0 in the PWM mode, a main output is high for exactly `threshold` counter ticks of every period. A threshold above the limit keeps it high all the time, and a threshold of 0 keeps it low all the time.
- R3: Setting a channel's main polarity bit inverts its main output while that output is enabled.
- R4: The complementary output is the inverse of the channel reference, XOR its own polarity bit, gated like the main output. With both outputs enabled and both polarities 0, the two outputs are always opposite.
- R5: An output drives 0 when its own enable bit is clear or when the master gate bit (register 11, bit 0) is clear.
- R6: When period preload (control bit 1) is set, a new limit takes effect only at the next update event. When it is clear, a new limit takes effect on the write, and a counter already above the new limit wraps on its next tick.
- R7: When a channel's compare-preload bit is set, a new threshold takes effect only at the next update event. When it is clear, the new threshold takes effect on the write.
- R8: Writing 1 to bit 0 of register 1 causes an update event and restarts the count at 0, so the output pattern begins at tick 0. The register always reads 0.
- R9: While the run bit (control bit 0) is clear, the counter holds its value and all outputs keep their level.
- R10: When the build has no complementary outputs, the complementary control bits ignore writes and read as 0, and every complementary output stays 0.
- R11: Output-control register 6 has one 4-bit group per channel at bit offset 4×channel: bit 0 main enable, bit 1 main polarity, bit 2 complementary enable, bit 3 complementary polarity. Each channel has an 8-bit mode byte. Register 4 holds channels 0 and 1, register 5 holds channels 2 and 3, and even channels use bits 7:0 while odd channels use bits 15:8. Within the byte, bit 3 is compare preload and bits 6:4 select the mode, where 3'b110 is PWM mode (reference high while count < threshold). Any other mode value holds the reference low.
- R12: The word addresses are 0 control, 1 event, 2 divider, 3 limit, 4–5 mode, 6 output control, 7–10 thresholds of channels 0–3, and 11 gate. Every register except the event register reads back its buffered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | N_CH | Main outputs |
| pwm_out_n | output | N_CH | Complementary outputs (0 when not built) |

## Verification
The assertions assume that every write request lasts exactly one clock. They also assume that the limit and the thresholds are changed only through the register port, so the active copies move only on an update event or on a direct write. The bench keeps within these assumptions: it raises the write strobe for a single cycle between falling edges and never drives the address while a write is pending. Duty checks count the high samples over whole periods, so the results do not depend on where in the period sampling begins. Exact-phase checks run only just after a software update event, because that event sets the count to 0.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_EVT    = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIV    = 4'd2;
  localparam logic [ADDR_W-1:0] A_LIMIT  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MODE01 = 4'd4;
  localparam logic [ADDR_W-1:0] A_OUTCFG = 4'd6;
  localparam logic [ADDR_W-1:0] A_THR0   = 4'd7;
  localparam logic [ADDR_W-1:0] A_GATE   = 4'd11;

  localparam logic [2:0] MODE_PWM = 3'b110;
endpackage

// File: rtl/pwm_tbase.sv
module pwm_tbase #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sw_upd,
  input  logic [DIV_W-1:0] div_buf,
  input  logic [CNT_W-1:0] lim_buf,
  input  logic             lim_direct,
  input  logic [CNT_W-1:0] lim_new,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  logic [DIV_W-1:0] div_cnt_q, div_cnt_d, div_act_q, div_act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_act_q, lim_act_d;
  logic             tick, wrap;

  always_comb begin
    tick = run && (div_cnt_q >= div_act_q);
    wrap = tick && (cnt_q >= lim_act_q);
    upd  = sw_upd || wrap;

    if (sw_upd || tick) div_cnt_d = '0;
    else if (run)       div_cnt_d = div_cnt_q + 1'b1;
    else                div_cnt_d = div_cnt_q;

    if (sw_upd || wrap) cnt_d = '0;
    else if (tick)      cnt_d = cnt_q + 1'b1;
    else                cnt_d = cnt_q;

    div_act_d = upd ? div_buf : div_act_q;

    if (lim_direct) lim_act_d = lim_new;
    else if (upd)   lim_act_d = lim_buf;
    else            lim_act_d = lim_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      div_act_q <= '0;
      cnt_q     <= '0;
      lim_act_q <= '0;
    end else begin
      div_cnt_q <= div_cnt_d;
      div_act_q <= div_act_d;
      cnt_q     <= cnt_d;
      lim_act_q <= lim_act_d;
    end
  end

  assign cnt = cnt_q;

  assert_div_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt_q <= div_act_q);
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !sw_upd) |=> $stable(cnt_q));
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_upd |=> (cnt_q == '0 && div_cnt_q == '0));
  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !sw_upd) |=> cnt_q == '0);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             upd,
  input  logic [7:0]       mode,
  input  logic [3:0]       cfg,
  input  logic             gate,
  input  logic [CNT_W-1:0] thr_buf,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_new,
  output logic             out_main,
  output logic             out_comp
);
  logic [CNT_W-1:0] thr_act_q, thr_act_d;
  logic             direct, refl;

  always_comb begin
    direct = thr_wr && !mode[3];
    if (direct)   thr_act_d = thr_new;
    else if (upd) thr_act_d = thr_buf;
    else          thr_act_d = thr_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_act_q <= '0;
    else        thr_act_q <= thr_act_d;
  end

  assign refl     = (mode[6:4] == MODE_PWM) && (cnt < thr_act_q);
  assign out_main = gate && cfg[0] && (refl ^ cfg[1]);

  generate
    if (HAS_COMP) begin : g_comp
      assign out_comp = gate && cfg[2] && (!refl ^ cfg[3]);
      assert_comp_opposite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && cfg == 4'b0101) |-> (out_main != out_comp));
    end else begin : g_nocomp
      assign out_comp = 1'b0;
    end
  endgenerate

  assert_thr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !direct) |=> $stable(thr_act_q));
endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
  import pwm_tmr_pkg::*;
#(
  parameter int N_CH     = 4,
  parameter int CNT_W    = 16,
  parameter int DIV_W    = 16,
  parameter bit HAS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   pwm_out,
  output logic [N_CH-1:0]   pwm_out_n
);
  localparam int CFG_W = 4 * N_CH;
  localparam logic [3:0] GRP_MASK = HAS_COMP ? 4'hF : 4'h3;
  localparam logic [CFG_W-1:0] CFG_MASK = {N_CH{GRP_MASK}};

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [1:0]       ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [7:0]       mode_q [N_CH];
  logic [7:0]       mode_d [N_CH];
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [CNT_W-1:0] thr_q [N_CH];
  logic [CNT_W-1:0] thr_d [N_CH];
  logic [N_CH-1:0]  thr_wr;
  logic             gate_q, gate_d;
  logic             sw_upd, lim_direct, upd;
  logic [CNT_W-1:0] cnt;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    lim_d  = lim_q;
    cfg_d  = cfg_q;
    gate_d = gate_q;
    if (bus_we) begin
      case (bus_addr)
        A_CTRL:   ctrl_d = bus_wdata[1:0];
        A_DIV:    div_d  = bus_wdata[DIV_W-1:0];
        A_LIMIT:  lim_d  = bus_wdata[CNT_W-1:0];
        A_OUTCFG: cfg_d  = bus_wdata[CFG_W-1:0] & CFG_MASK;
        A_GATE:   gate_d = bus_wdata[0];
        default:  ;
      endcase
    end
    for (int i = 0; i < N_CH; i++) begin
      mode_d[i] = mode_q[i];
      thr_d[i]  = thr_q[i];
      thr_wr[i] = bus_we && (bus_addr == ADDR_W'(A_THR0 + i));
      if (bus_we && bus_addr == ADDR_W'(A_MODE01 + i / 2))
        mode_d[i] = bus_wdata[(i % 2) * 8 +: 8];
      if (thr_wr[i]) thr_d[i] = bus_wdata[CNT_W-1:0];
    end
    sw_upd     = bus_we && (bus_addr == A_EVT) && bus_wdata[0];
    lim_direct = bus_we && (bus_addr == A_LIMIT) && !ctrl_q[1];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0;
      div_q  <= '0;
      lim_q  <= '0;
      cfg_q  <= '0;
      gate_q <= 1'b0;
      for (int i = 0; i < N_CH; i++) begin
        mode_q[i] <= '0;
        thr_q[i]  <= '0;
      end
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      lim_q  <= lim_d;
      cfg_q  <= cfg_d;
      gate_q <= gate_d;
      for (int i = 0; i < N_CH; i++) begin
        mode_q[i] <= mode_d[i];
        thr_q[i]  <= thr_d[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata[1:0]       = ctrl_q;
      A_DIV:    bus_rdata[DIV_W-1:0] = div_q;
      A_LIMIT:  bus_rdata[CNT_W-1:0] = lim_q;
      A_OUTCFG: bus_rdata[CFG_W-1:0] = cfg_q;
      A_GATE:   bus_rdata[0]         = gate_q;
      default:  ;
    endcase
    for (int i = 0; i < N_CH; i++) begin
      if (bus_addr == ADDR_W'(A_MODE01 + i / 2)) bus_rdata[(i % 2) * 8 +: 8] = mode_q[i];
      if (bus_addr == ADDR_W'(A_THR0 + i))       bus_rdata[CNT_W-1:0] = thr_q[i];
    end
  end

  pwm_tbase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tbase (
    .clk(clk), .rst_n(rst_i), .run(ctrl_q[0]), .sw_upd(sw_upd),
    .div_buf(div_q), .lim_buf(lim_q), .lim_direct(lim_direct),
    .lim_new(bus_wdata[CNT_W-1:0]), .cnt(cnt), .upd(upd)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      pwm_chan #(.CNT_W(CNT_W), .HAS_COMP(HAS_COMP)) u_ch (
        .clk(clk), .rst_n(rst_i), .cnt(cnt), .upd(upd), .mode(mode_q[c]),
        .cfg(cfg_q[4*c +: 4]), .gate(gate_q), .thr_buf(thr_q[c]),
        .thr_wr(thr_wr[c]), .thr_new(bus_wdata[CNT_W-1:0]),
        .out_main(pwm_out[c]), .out_comp(pwm_out_n[c])
      );
    end
  endgenerate

  assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (!gate_q && !$past(gate_q)) |-> (pwm_out == '0 && pwm_out_n == '0));
  assert_cfg_masked_R10: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_q & ~CFG_MASK) == '0);
endmodule

// File: tb/tb_pwm_tmr_core.sv
module tb_pwm_tmr_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, nc_we;
  logic [31:0] bus_rdata, nc_rdata;
  logic [3:0]  pwm_out, pwm_out_n, nc_out, nc_out_n;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_tmr_core dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pwm_out_n(pwm_out_n)
  );

  pwm_tmr_core #(.HAS_COMP(1'b0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(nc_we), .bus_rdata(nc_rdata), .pwm_out(nc_out), .pwm_out_n(nc_out_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_nc(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; nc_we = 1'b1;
    @(negedge clk);
    nc_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    bus_addr = a; #1; d = int'(bus_rdata);
  endtask

  task automatic count_hi(input int n, input bit comp, output int k);
    k = 0;
    for (int s = 0; s < n; s++) begin
      if (comp ? pwm_out_n[0] : pwm_out[0]) k++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int d;
    check("R5 reset outputs", int'(pwm_out), 0);
    rd(4'd6, d); check("R12 reset outcfg", d, 0);
    rd(4'd3, d); check("R12 reset limit", d, 0);
  endtask

  task automatic t_duty;
    int k;
    wr(4'd11, 1); wr(4'd4, 32'h6868); wr(4'd6, 32'h1);
    wr(4'd2, 0); wr(4'd3, 9); wr(4'd7, 3); wr(4'd1, 1); wr(4'd0, 3);
    count_hi(10, 0, k); check("R2 duty 3 of 10", k, 3);
    wr(4'd6, 32'h3); count_hi(10, 0, k); check("R3 inverted duty", k, 7);
    wr(4'd6, 32'h5);
    for (int s = 0; s < 10; s++) begin
      check("R4 opposite", int'(pwm_out[0] ^ pwm_out_n[0]), 1);
      @(negedge clk);
    end
    count_hi(10, 1, k); check("R4 comp duty", k, 7);
    wr(4'd6, 32'hD); count_hi(10, 1, k); check("R4 comp inverted", k, 3);
    wr(4'd6, 32'h1);
    wr(4'd7, 12); wr(4'd1, 1); count_hi(10, 0, k); check("R2 thr above limit", k, 10);
    wr(4'd7, 0);  wr(4'd1, 1); count_hi(10, 0, k); check("R2 thr zero", k, 0);
  endtask

  task automatic t_mode;
    int k;
    wr(4'd4, 32'h6818); wr(4'd7, 5); wr(4'd1, 1);
    count_hi(10, 0, k); check("R11 non-PWM mode low", k, 0);
    wr(4'd4, 32'h6868); wr(4'd1, 1);
    count_hi(10, 0, k); check("R11 PWM mode restored", k, 5);
  endtask

  task automatic t_div;
    int k;
    wr(4'd2, 2); wr(4'd3, 3); wr(4'd7, 1); wr(4'd1, 1);
    count_hi(24, 0, k); check("R1 divider 3 period 12", k, 6);
    wr(4'd2, 0); wr(4'd3, 9); wr(4'd7, 5); wr(4'd1, 1);
  endtask

  task automatic t_limit;
    int k, d;
    wr(4'd3, 19);
    rd(4'd3, d); check("R12 limit readback", d, 19);
    for (int s = 0; s < 12; s++) @(negedge clk);
    count_hi(20, 0, k); check("R6 buffered limit after wrap", k, 5);
    wr(4'd0, 1); wr(4'd3, 4);
    for (int s = 0; s < 25; s++) @(negedge clk);
    count_hi(5, 0, k); check("R6 direct limit", k, 5);
    wr(4'd0, 3); wr(4'd3, 9); wr(4'd1, 1);
  endtask

  task automatic t_ug;
    int d;
    wr(4'd1, 1);
    for (int s = 0; s < 10; s++) begin
      check("R8 phase after event", int'(pwm_out[0]), s < 5 ? 1 : 0);
      @(negedge clk);
    end
    rd(4'd1, d); check("R8 event reads 0", d, 0);
  endtask

  task automatic t_preload;
    int k;
    wr(4'd0, 2); wr(4'd7, 5); wr(4'd1, 1);
    check("R7 loaded on event", int'(pwm_out[0]), 1);
    wr(4'd7, 0);
    check("R7 buffered thr held", int'(pwm_out[0]), 1);
    count_hi(10, 0, k); check("R9 frozen output", k, 10);
    wr(4'd1, 1);
    check("R7 thr loaded by event", int'(pwm_out[0]), 0);
    wr(4'd4, 32'h6860); wr(4'd7, 5);
    check("R7 direct thr", int'(pwm_out[0]), 1);
    wr(4'd4, 32'h6868); wr(4'd0, 3);
  endtask

  task automatic t_gate;
    int k;
    wr(4'd11, 0); count_hi(10, 0, k); check("R5 master gate off", k, 0);
    wr(4'd11, 1); wr(4'd6, 32'h0); count_hi(10, 0, k); check("R5 channel off", k, 0);
    wr(4'd6, 32'h1); count_hi(10, 0, k); check("R5 re-enabled", k, 5);
    check("R5 unused channels", int'(pwm_out[3:1]), 0);
  endtask

  task automatic t_regs;
    int d;
    wr(4'd9, 32'h1234); rd(4'd9, d); check("R12 thr2 readback", d, 32'h1234);
    wr(4'd5, 32'hA55A); rd(4'd5, d); check("R11 mode23 readback", d, 32'hA55A);
    wr(4'd2, 7); rd(4'd2, d); check("R12 divider readback", d, 7);
    wr(4'd2, 0); wr(4'd1, 1);
  endtask

  task automatic t_nocomp;
    wr_nc(4'd11, 1); wr_nc(4'd6, 32'hFFFF);
    bus_addr = 4'd6; #1;
    check("R10 comp bits masked", int'(nc_rdata), 32'h3333);
    for (int s = 0; s < 5; s++) begin
      check("R10 comp outputs 0", int'(nc_out_n), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; nc_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset; t_duty; t_mode; t_div; t_limit; t_ug; t_preload; t_gate; t_regs; t_nocomp;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule